// File: doc/BRIEF.md
# Serial Bit-Rate Auto-Match with Confirmation Handshake

This block lets a serial boot loader adopt whatever bit rate a host happens to use, before any boot data moves. While the host streams zero bytes, the block times how long the receive line stays low for one of them. A zero byte together with its start bit holds the line low for nine bit times, so the count divided by nine, rounded to the nearest integer, gives the bit period in system clocks. That value goes out on `divisor`.

The block then answers at the new rate with a single zero byte and waits for the host's probe byte 0x55. Further zero bytes that the host is still sending are ignored. A correct probe is echoed as 0x55, and `locked` rises once the echo has left the wire. Any other byte, or a byte with a bad stop bit, raises `hs_fail` and is answered with 0xAA. After a short startup delay following reset, measurement begins only once the line has been seen idle high. Low pulses that are too short or too long for the supported rate window are thrown away, and the block waits for the next one.

Top module: `baud_match`

## Requirements
- R1: After reset, `txd` is 1, `locked` is 0, `hs_fail` is 0 and `divisor` is 0.
- R2: For START_DLY cycles after reset nothing on `rxd` is measured. After that delay, the line must be seen high before a low pulse is timed, so a low pulse that began during the delay is ignored.
- R3: A timed low pulse of L clock cycles sets `divisor` to round(L/9), computed as floor((L+4)/9); for example 112 gives 12 and 113 gives 13.
- R4: A low pulse shorter than 9*MIN_DIV-4 cycles is ignored: `divisor` is unchanged, no byte is sent, and the next low pulse is timed.
- R5: A low pulse longer than 9*MAX_DIV+4 cycles is ignored and timing restarts on the next low pulse after the line returns high; a pulse of exactly 9*MAX_DIV+4 cycles is accepted.
- R6: Once a pulse is accepted, the block sends 0x00 on `txd` as a start bit (0), eight data bits LSB first and a stop bit (1), each `divisor` cycles long. `txd` idles at 1.
- R7: While waiting for the probe, received 0x00 bytes with a valid stop bit are ignored: no reply, and no change to `locked` or `hs_fail`.
- R8: A received 0x55 with a valid stop bit is echoed as 0x55. `locked` rises after the stop bit of that echo and stays high until reset.
- R9: Any other received byte, or one whose stop bit is 0, sets `hs_fail` (held until reset) and is answered with 0xAA. `locked` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line from the host (asynchronous) |
| txd | output | 1 | Serial transmit line to the host |
| divisor | output | DIV_W (13 by default) | Derived bit period in clock cycles |
| locked | output | 1 | Handshake completed successfully |
| hs_fail | output | 1 | Handshake failed on a wrong probe byte |

## Verification
The awkward corners are the edges of the acceptance window and the startup delay. Both depend on the exact number of low cycles, not on bytes. The bench therefore drives raw low pulses of chosen length: one cycle either side of each limit, and the rounding neighbours 112 and 113. It also starts a long low pulse inside the delay window and holds it past the end of the window. Reaching the handshake needs full-duplex stimulus, so the host byte and a decoder on `txd` run in parallel, and a stray zero byte is sent before the probe.

// File: rtl/baud_match_pkg.sv
package baud_match_pkg;

    typedef enum logic [2:0] {
        M_DELAY,
        M_WAITHI,
        M_ARM,
        M_MEAS,
        M_DONE
    } meter_st_e;

    typedef enum logic [1:0] {
        R_IDLE,
        R_START,
        R_DATA,
        R_STOP
    } rx_st_e;

    typedef enum logic [2:0] {
        S_MEAS,
        S_LISTEN,
        S_RESP,
        S_WAITTX,
        S_LOCK,
        S_FAIL
    } seq_st_e;

    localparam logic [7:0] BYTE_SYNC  = 8'h00;
    localparam logic [7:0] BYTE_PROBE = 8'h55;
    localparam logic [7:0] BYTE_NAK   = 8'hAA;

endpackage

// File: rtl/baud_match_sync.sv
module baud_match_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/baud_match_meter.sv
module baud_match_meter
    import baud_match_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int DIV_W     = 13,
    parameter int START_DLY = 100,
    parameter int MIN_LOW   = 68,
    parameter int LOW_LIMIT = 37804,
    parameter int MIN_DIV   = 8,
    parameter int MAX_DIV   = 4200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd_s,
    output logic             done_o,
    output logic [DIV_W-1:0] div_o
);
    typedef struct packed {
        meter_st_e        st;
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic             done;
    } meter_t;

    meter_t m_d, m_q;
    logic [CNT_W:0] rounded;

    always_comb rounded = ({1'b0, m_q.cnt} + (CNT_W+1)'(4)) / (CNT_W+1)'(9);

    always_comb begin
        m_d      = m_q;
        m_d.done = 1'b0;
        case (m_q.st)
            M_DELAY: begin
                if (m_q.cnt >= CNT_W'(START_DLY - 1)) begin
                    m_d.st  = M_WAITHI;
                    m_d.cnt = '0;
                end else begin
                    m_d.cnt = m_q.cnt + 1'b1;
                end
            end
            M_WAITHI: if (rxd_s) m_d.st = M_ARM;
            M_ARM: begin
                if (!rxd_s) begin
                    m_d.st  = M_MEAS;
                    m_d.cnt = CNT_W'(1);
                end
            end
            M_MEAS: begin
                if (rxd_s) begin
                    if (m_q.cnt < CNT_W'(MIN_LOW)) begin
                        m_d.st = M_ARM;
                    end else begin
                        m_d.st   = M_DONE;
                        m_d.div  = DIV_W'(rounded);
                        m_d.done = 1'b1;
                    end
                    m_d.cnt = '0;
                end else if (m_q.cnt >= CNT_W'(LOW_LIMIT)) begin
                    m_d.st  = M_WAITHI;
                    m_d.cnt = '0;
                end else begin
                    m_d.cnt = m_q.cnt + 1'b1;
                end
            end
            default: m_d.st = M_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.st   <= M_DELAY;
            m_q.cnt  <= '0;
            m_q.div  <= '0;
            m_q.done <= 1'b0;
        end else begin
            m_q <= m_d;
        end
    end

    assign done_o = m_q.done;
    assign div_o  = m_q.div;

    p_div_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (div_o >= DIV_W'(MIN_DIV) && div_o <= DIV_W'(MAX_DIV)));

    p_div_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.st != M_MEAS) |=> $stable(div_o));
endmodule

// File: rtl/baud_match_rx.sv
module baud_match_rx
    import baud_match_pkg::*;
#(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rxd_s,
    input  logic [DIV_W-1:0] div,
    output logic             valid_o,
    output logic [7:0]       data_o,
    output logic             frame_ok_o
);
    typedef struct packed {
        rx_st_e           st;
        logic [DIV_W-1:0] cnt;
        logic [2:0]       bitn;
        logic [7:0]       sh;
        logic             prev;
        logic             valid;
        logic             ok;
    } rx_t;

    rx_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.prev  = rxd_s;
        case (r_q.st)
            R_IDLE: begin
                if (en && r_q.prev && !rxd_s) begin
                    r_d.st  = R_START;
                    r_d.cnt = '0;
                end
            end
            R_START: begin
                if (r_q.cnt == (div >> 1)) begin
                    r_d.cnt  = '0;
                    r_d.bitn = '0;
                    r_d.st   = rxd_s ? R_IDLE : R_DATA;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            R_DATA: begin
                if (r_q.cnt == div - 1'b1) begin
                    r_d.cnt  = '0;
                    r_d.sh   = {rxd_s, r_q.sh[7:1]};
                    r_d.bitn = r_q.bitn + 1'b1;
                    if (r_q.bitn == 3'd7) r_d.st = R_STOP;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: begin
                if (r_q.cnt == div - 1'b1) begin
                    r_d.cnt   = '0;
                    r_d.valid = 1'b1;
                    r_d.ok    = rxd_s;
                    r_d.st    = R_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= R_IDLE;
            r_q.cnt   <= '0;
            r_q.bitn  <= '0;
            r_q.sh    <= '0;
            r_q.prev  <= 1'b1;
            r_q.valid <= 1'b0;
            r_q.ok    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign valid_o    = r_q.valid;
    assign data_o     = r_q.sh;
    assign frame_ok_o = r_q.ok;

    p_rx_only_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && r_q.st == R_IDLE) |=> (r_q.st == R_IDLE));
endmodule

// File: rtl/baud_match_tx.sv
module baud_match_tx #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       data,
    input  logic [DIV_W-1:0] div,
    output logic             txd,
    output logic             busy,
    output logic             done
);
    typedef struct packed {
        logic             busy;
        logic [9:0]       sh;
        logic [DIV_W-1:0] cnt;
        logic [3:0]       bitn;
        logic             done;
    } tx_t;

    tx_t t_d, t_q;

    always_comb begin
        t_d      = t_q;
        t_d.done = 1'b0;
        if (!t_q.busy) begin
            if (start) begin
                t_d.busy = 1'b1;
                t_d.sh   = {1'b1, data, 1'b0};
                t_d.cnt  = '0;
                t_d.bitn = '0;
            end
        end else if (t_q.cnt == div - 1'b1) begin
            t_d.cnt = '0;
            if (t_q.bitn == 4'd9) begin
                t_d.busy = 1'b0;
                t_d.done = 1'b1;
                t_d.sh   = '1;
            end else begin
                t_d.sh   = {1'b1, t_q.sh[9:1]};
                t_d.bitn = t_q.bitn + 1'b1;
            end
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.busy <= 1'b0;
            t_q.sh   <= '1;
            t_q.cnt  <= '0;
            t_q.bitn <= '0;
            t_q.done <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign txd  = t_q.sh[0];
    assign busy = t_q.busy;
    assign done = t_q.done;

    p_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);
    p_start_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);
endmodule

// File: rtl/baud_match.sv
module baud_match
    import baud_match_pkg::*;
#(
    parameter int MAX_DIV     = 4200,
    parameter int MIN_DIV     = 8,
    parameter int START_DLY   = 100,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = $clog2(MAX_DIV + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    output logic             txd,
    output logic [DIV_W-1:0] divisor,
    output logic             locked,
    output logic             hs_fail
);
    localparam int LOW_LIMIT = 9 * MAX_DIV + 4;
    localparam int MIN_LOW   = 9 * MIN_DIV - 4;
    localparam int CNT_MAX   = (LOW_LIMIT > START_DLY) ? LOW_LIMIT : START_DLY;
    localparam int CNT_W     = $clog2(CNT_MAX + 16) + 1;

    typedef struct packed {
        seq_st_e    st;
        logic       start;
        logic [7:0] byte_out;
        logic       locked;
        logic       fail;
    } seq_t;

    seq_t s_d, s_q;

    logic             rxd_s;
    logic             meas_done;
    logic [DIV_W-1:0] div_w;
    logic             rx_valid, rx_ok, tx_busy, tx_done;
    logic [7:0]       rx_data;

    baud_match_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
    );

    baud_match_meter #(
        .CNT_W(CNT_W), .DIV_W(DIV_W), .START_DLY(START_DLY),
        .MIN_LOW(MIN_LOW), .LOW_LIMIT(LOW_LIMIT),
        .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV)
    ) u_meter (
        .clk(clk), .rst_n(rst_n), .rxd_s(rxd_s),
        .done_o(meas_done), .div_o(div_w)
    );

    baud_match_rx #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(s_q.st == S_LISTEN), .rxd_s(rxd_s),
        .div(div_w), .valid_o(rx_valid), .data_o(rx_data), .frame_ok_o(rx_ok)
    );

    baud_match_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(s_q.start), .data(s_q.byte_out),
        .div(div_w), .txd(txd), .busy(tx_busy), .done(tx_done)
    );

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        case (s_q.st)
            S_MEAS: begin
                if (meas_done) begin
                    s_d.start    = 1'b1;
                    s_d.byte_out = BYTE_SYNC;
                    s_d.st       = S_LISTEN;
                end
            end
            S_LISTEN: begin
                if (rx_valid) begin
                    if (rx_ok && rx_data == BYTE_SYNC) begin
                        s_d.st = S_LISTEN;
                    end else if (rx_ok && rx_data == BYTE_PROBE) begin
                        s_d.byte_out = BYTE_PROBE;
                        s_d.st       = S_RESP;
                    end else begin
                        s_d.byte_out = BYTE_NAK;
                        s_d.fail     = 1'b1;
                        s_d.st       = S_RESP;
                    end
                end
            end
            S_RESP: begin
                if (!tx_busy && !s_q.start) begin
                    s_d.start = 1'b1;
                    s_d.st    = S_WAITTX;
                end
            end
            S_WAITTX: begin
                if (tx_done) begin
                    s_d.st     = s_q.fail ? S_FAIL : S_LOCK;
                    s_d.locked = !s_q.fail;
                end
            end
            default: s_d.st = s_q.st;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st       <= S_MEAS;
            s_q.start    <= 1'b0;
            s_q.byte_out <= BYTE_SYNC;
            s_q.locked   <= 1'b0;
            s_q.fail     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign divisor = div_w;
    assign locked  = s_q.locked;
    assign hs_fail = s_q.fail;

    p_lock_fail_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && hs_fail));
    p_quiet_before_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_MEAS) |-> txd);
    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
    p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hs_fail |=> hs_fail);
endmodule

// File: tb/sim_baud_match.sv
`timescale 1ns/1ps
module sim_baud_match;
    localparam int MAX_DIV = 40;
    localparam int MIN_DIV = 4;
    localparam int DLY     = 100;
    localparam int DW      = $clog2(MAX_DIV + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rxd = 1'b1;
    logic          txd;
    logic [DW-1:0] divisor;
    logic          locked, hs_fail;
    int            n_chk = 0;
    int            n_err = 0;
    bit            ended = 1'b0;

    always #5 clk = ~clk;

    baud_match #(.MAX_DIV(MAX_DIV), .MIN_DIV(MIN_DIV), .START_DLY(DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd),
        .divisor(divisor), .locked(locked), .hs_fail(hs_fail)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rxd   = 1'b1;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic low_pulse(input int len);
        rxd = 1'b0;
        repeat (len) @(negedge clk);
        rxd = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, input int t);
        logic [9:0] fr;
        fr = {1'b1, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            rxd = fr[i];
            repeat (t) @(negedge clk);
        end
    endtask

    task automatic recv_byte(input int t, output logic [7:0] b, output bit seen);
        int w;
        w = 0; seen = 1'b0; b = 8'h00;
        while (txd !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
        if (txd === 1'b0) begin
            seen = 1'b1;
            repeat (t / 2) @(negedge clk);
            for (int i = 0; i < 8; i++) begin
                repeat (t) @(negedge clk);
                b[i] = txd;
            end
            repeat (t) @(negedge clk);
            if (txd !== 1'b1) seen = 1'b0;
        end
    endtask

    task automatic tx_low_run(output int n);
        int w;
        w = 0; n = 0;
        while (txd !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
        while (txd === 1'b0 && n < 4000) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 txd", txd, 1);
        chk("R1 locked", locked, 0);
        chk("R1 hs_fail", hs_fail, 0);
        chk("R1 divisor", divisor, 0);
        do_reset();
    endtask

    task automatic t_startup_delay();
        do_reset();
        repeat (5) @(negedge clk);
        low_pulse(180);
        repeat (10) @(negedge clk);
        chk("R2 divisor after early pulse", divisor, 0);
        chk("R2 txd quiet", txd, 1);
        low_pulse(9 * 15);
        repeat (6) @(negedge clk);
        chk("R2 later pulse timed", divisor, 15);
    endtask

    task automatic t_rate(input int t);
        int n;
        do_reset();
        repeat (DLY + 5) @(negedge clk);
        fork
            send_byte(8'h00, t);
            tx_low_run(n);
        join
        chk($sformatf("R3 divisor at bit time %0d", t), divisor, t);
        chk($sformatf("R6 zero byte low run at %0d", t), n, 9 * t);
        repeat (2 * t) @(negedge clk);
        chk("R6 txd idle after byte", txd, 1);
    endtask

    task automatic t_round(input int len, input int exp);
        do_reset();
        repeat (DLY + 5) @(negedge clk);
        low_pulse(len);
        repeat (6) @(negedge clk);
        chk($sformatf("R3 rounding of %0d", len), divisor, exp);
    endtask

    task automatic t_window();
        do_reset();
        repeat (DLY + 5) @(negedge clk);
        low_pulse(9 * MIN_DIV - 5);
        repeat (10) @(negedge clk);
        chk("R4 short pulse ignored", divisor, 0);
        chk("R4 no reply to short pulse", txd, 1);
        low_pulse(9 * MIN_DIV - 4);
        repeat (6) @(negedge clk);
        chk("R4 shortest accepted", divisor, MIN_DIV);
        do_reset();
        repeat (DLY + 5) @(negedge clk);
        low_pulse(9 * MAX_DIV + 5);
        repeat (10) @(negedge clk);
        chk("R5 long pulse ignored", divisor, 0);
        chk("R5 no reply to long pulse", txd, 1);
        low_pulse(9 * MAX_DIV + 4);
        repeat (6) @(negedge clk);
        chk("R5 longest accepted", divisor, MAX_DIV);
    endtask

    task automatic t_lock(input int t);
        logic [7:0] b;
        bit s;
        do_reset();
        repeat (DLY + 5) @(negedge clk);
        fork
            send_byte(8'h00, t);
            recv_byte(t, b, s);
        join
        chk("R6 sync byte seen", s, 1);
        chk("R6 sync byte value", b, 8'h00);
        send_byte(8'h00, t);
        repeat (3 * t) @(negedge clk);
        chk("R7 stray zero gives no lock", locked, 0);
        chk("R7 stray zero gives no fail", hs_fail, 0);
        chk("R7 stray zero gives no reply", txd, 1);
        fork
            send_byte(8'h55, t);
            recv_byte(t, b, s);
        join
        chk("R8 echo seen", s, 1);
        chk("R8 echo value", b, 8'h55);
        repeat (t + 4) @(negedge clk);
        chk("R8 locked", locked, 1);
        chk("R8 no fail", hs_fail, 0);
    endtask

    task automatic t_fail(input int t);
        logic [7:0] b;
        bit s;
        do_reset();
        repeat (DLY + 5) @(negedge clk);
        fork
            send_byte(8'h00, t);
            recv_byte(t, b, s);
        join
        fork
            send_byte(8'h5A, t);
            recv_byte(t, b, s);
        join
        chk("R9 nak seen", s, 1);
        chk("R9 nak value", b, 8'hAA);
        repeat (t + 4) @(negedge clk);
        chk("R9 fail set", hs_fail, 1);
        chk("R9 not locked", locked, 0);
    endtask

    initial begin
        t_reset_state();
        t_startup_delay();
        t_rate(20);
        t_rate(13);
        t_rate(33);
        t_round(112, 12);
        t_round(113, 13);
        t_window();
        t_lock(20);
        t_fail(16);
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule